// File: doc/BRIEF.md
# Sticky-Pending Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines from peripherals and drives a single registered request line to a CPU core. Every cycle it samples each input into a level-state register. Any line seen high sets a pending bit, and that bit stays set until software acknowledges it. A 32-bit enable mask decides which pending bits may raise the request.

The CPU reaches the mask and the pending register through a small register port with read, write, select and write data. Writing the pending register acknowledges interrupts, one bit per line. The merge with the current levels happens again on every cycle, so a line that is still held high is pending again straight after its acknowledge. A separate read port gives access to a bank of per-line counters, one counter per line, each counting rising edges of its input for diagnostics.

Top module: `picx_ctrl`

## Requirements
- R1: The block has NUM_LINES (default 32) lines numbered 0 to NUM_LINES-1. Bit i of the mask, of the pending register and of every data word belongs to line `irq_in[i]`. This includes lines 0 and 31.
- R2: A level-state register captures `irq_in` on every rising clock edge. On the next edge, each line whose captured level is 1 sets its pending bit.
- R3: A pending bit stays set after its input returns low. Only an acknowledge clears it.
- R4: `cpu_irq` is a flop. After each edge it equals the OR over all lines of (pending AND mask) as those registers stood before that edge, so it follows a register change by exactly one cycle.
- R5: A write with `reg_sel`=1 is an acknowledge. Each bit of `reg_wdata` that is 1 clears that pending bit, and each bit that is 0 leaves its pending bit unchanged.
- R6: If an acknowledge meets a line whose captured level is still 1, that pending bit ends the cycle set.
- R7: Pending bits are set whether or not the line is masked. Enabling the mask later raises `cpu_irq` for an interrupt that is already pending.
- R8: A read with `reg_sel`=0 returns the mask and with `reg_sel`=1 returns the pending register. `reg_rdata` is registered: it is valid one edge after `reg_rd` and holds its value while no read is made.
- R9: Synchronous active-high `rst` clears the mask, the pending register, the level state, all event counters, `cpu_irq` and both read-data registers.
- R10: Each line's CNT_W-bit counter increments when its input goes from a captured low to a sampled high, and wraps around on overflow. `cnt_rdata` shows the counter selected by `cnt_sel` one edge later.
- R11: A write with `reg_sel`=0 loads `reg_wdata` into the mask on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Level interrupt inputs from peripherals |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mask, 1 selects the pending register |
| reg_wdata | input | NUM_LINES | Write data: a new mask, or the acknowledge bits |
| reg_rdata | output | NUM_LINES | Registered read data |
| cnt_sel | input | IDX_W | Line whose event counter is read |
| cnt_rdata | output | CNT_W | Registered event counter value |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The bound checker checks on every cycle the invariants of the pending path:
- No pending bit drops without an acknowledge.
- No pending bit appears without a captured high level.
- A captured high level is always absorbed into pending, even through an acknowledge.
- A mask write lands exactly.
- The request flop tracks the masked pending state one cycle behind.

Some properties depend on the order of stimulus and are left to the bench scenarios and its cycle-by-cycle reference model:
- Masked latching followed by a later enable.
- Counter totals after a mix of pulses and held levels.
- Wrap-free counting of held lines.
- Read-data latency.
- Clearing of every register by a reset in mid-run.

// File: rtl/picx_pkg.sv
package picx_pkg;
  // register port select encodings
  localparam logic SEL_MASK = 1'b0;
  localparam logic SEL_PEND = 1'b1;
endpackage

// File: rtl/picx_level_stage.sv
module picx_level_stage #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] lvl_q,
  output logic [NUM_LINES-1:0] rise
);
  // one flop stage holding the current input levels
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= irq_in;
  end

  // a line is rising when sampled high while its held level is low
  always_comb rise = irq_in & ~lvl_q;
endmodule

// File: rtl/picx_pend_core.sv
module picx_pend_core #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lvl_q,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic [NUM_LINES-1:0] ack_vec,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pend_q,
  output logic                 req_q
);
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] mask_d;

  // clear acknowledged bits, then merge the held levels back in,
  // so a line still high wins over its own acknowledge
  always_comb begin
    pend_d = (pend_q & ~ack_vec) | lvl_q;
    mask_d = mask_wr ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      req_q  <= |(pend_q & mask_q);
    end
  end
endmodule

// File: rtl/picx_event_bank.sv
module picx_event_bank #(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rise,
  input  logic [IDX_W-1:0]     cnt_sel,
  output logic [CNT_W-1:0]     cnt_rdata
);
  logic [CNT_W-1:0] cnt_q [NUM_LINES];

  // each line gets its own counter, since many lines may rise in one cycle
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)          cnt_q[g] <= '0;
      else if (rise[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  // registered read; an index past the last line reads zero
  always_ff @(posedge clk) begin
    if (rst) cnt_rdata <= '0;
    else if (int'(cnt_sel) < NUM_LINES) cnt_rdata <= cnt_q[cnt_sel];
    else cnt_rdata <= '0;
  end
endmodule

// File: rtl/picx_regport.sv
module picx_regport #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [NUM_LINES-1:0] reg_wdata,
  input  logic [NUM_LINES-1:0] mask_q,
  input  logic [NUM_LINES-1:0] pend_q,
  output logic                 mask_wr,
  output logic [NUM_LINES-1:0] ack_vec,
  output logic [NUM_LINES-1:0] reg_rdata
);
  import picx_pkg::*;

  always_comb begin
    mask_wr = reg_wr && (reg_sel == SEL_MASK);
    ack_vec = (reg_wr && (reg_sel == SEL_PEND)) ? reg_wdata : '0;
  end

  // read data holds between reads
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_sel == SEL_PEND) ? pend_q : mask_q;
  end
endmodule

// File: rtl/picx_ctrl.sv
module picx_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [IDX_W-1:0]     cnt_sel,
  output logic [CNT_W-1:0]     cnt_rdata,
  output logic                 cpu_irq
);
  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] ack_vec;
  logic                 mask_wr;

  picx_level_stage #(.NUM_LINES(NUM_LINES)) u_lvl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_q(lvl_q), .rise(rise)
  );

  picx_regport #(.NUM_LINES(NUM_LINES)) u_port (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .mask_q(mask_q),
    .pend_q(pend_q), .mask_wr(mask_wr), .ack_vec(ack_vec),
    .reg_rdata(reg_rdata)
  );

  picx_pend_core #(.NUM_LINES(NUM_LINES)) u_core (
    .clk(clk), .rst(rst), .lvl_q(lvl_q), .mask_wr(mask_wr),
    .mask_wdata(reg_wdata), .ack_vec(ack_vec), .mask_q(mask_q),
    .pend_q(pend_q), .req_q(cpu_irq)
  );

  picx_event_bank #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .cnt_sel(cnt_sel),
    .cnt_rdata(cnt_rdata)
  );
endmodule

// File: rtl/picx_ctrl_chk.sv
module picx_ctrl_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic                 reg_sel,
  input logic [NUM_LINES-1:0] reg_wdata,
  input logic [NUM_LINES-1:0] lvl_q,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 cpu_irq
);
  logic [NUM_LINES-1:0] ack_seen;
  always_comb ack_seen = (reg_wr && reg_sel) ? reg_wdata : '0;

  // R3: a pending bit drops only when acknowledged
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~$past(ack_seen) & ~pend_q) == '0));

  // R2 / R6: a captured high level is always pending on the next edge
  a_r6_level_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lvl_q) & ~pend_q) == '0));

  // R2: no pending bit appears without a captured high level
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(lvl_q)) == '0));

  // R11: a mask write lands exactly
  a_r11_mask_load: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=> (mask_q == $past(reg_wdata)));

  // R4: request is the masked pending state one cycle late
  a_r4_req_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == ($past(pend_q & mask_q) != '0)));
endmodule

bind picx_ctrl picx_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .lvl_q(lvl_q), .pend_q(pend_q),
  .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/picx_ctrl_tb.sv
`timescale 1ns/1ps
module picx_ctrl_tb_top;
  localparam int N  = 32;
  localparam int CW = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic [IW-1:0] cnt_sel = '0;
  logic [CW-1:0] cnt_rdata;
  logic          cpu_irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  picx_ctrl #(.NUM_LINES(N), .CNT_W(CW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata),
    .cpu_irq(cpu_irq)
  );

  // behavioural reference model
  bit [31:0] m_lvl, m_pend, m_mask, m_rdata, m_crdata;
  bit        m_irq;
  int unsigned m_cnt [N];

  always @(posedge clk) begin
    bit [31:0] ack, np, nm;
    if (rst) begin
      m_lvl = 0; m_pend = 0; m_mask = 0; m_rdata = 0; m_crdata = 0; m_irq = 0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      ack = (reg_wr && reg_sel) ? reg_wdata : 32'h0;
      np  = (m_pend & ~ack) | m_lvl;
      nm  = (reg_wr && !reg_sel) ? reg_wdata : m_mask;
      m_irq = (m_pend & m_mask) != 0;
      if (reg_rd) m_rdata = reg_sel ? m_pend : m_mask;
      m_crdata = m_cnt[cnt_sel];
      for (int i = 0; i < N; i++)
        if (irq_in[i] && !m_lvl[i]) m_cnt[i]++;
      m_lvl = irq_in; m_pend = np; m_mask = nm;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 cpu_irq model", {31'b0, cpu_irq}, {31'b0, m_irq});
      check("R8 reg_rdata model", reg_rdata, m_rdata);
      check("R10 cnt_rdata model", cnt_rdata, m_crdata);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] v);
    reg_rd = 1'b1; reg_sel = sel;
    step();
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic rdcnt(int line, output logic [31:0] v);
    cnt_sel = IW'(line);
    step(2);
    v = cnt_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    step(3);
    rst = 1'b0;
    step();
    check("R9 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
    rd(1'b0, v); check("R9 mask after reset", v, 32'h0);
    rd(1'b1, v); check("R9 pending after reset", v, 32'h0);

    // one-cycle pulse on masked line 3
    irq_in[3] = 1'b1; step(); irq_in[3] = 1'b0; step(3);
    rd(1'b1, v); check("R2 R3 R7 pulse latched while masked", v, 32'h8);
    check("R7 no request while masked", {31'b0, cpu_irq}, 32'h0);
    wr(1'b0, 32'h8); step(2);
    check("R7 enable raises request", {31'b0, cpu_irq}, 32'h1);
    rd(1'b0, v); check("R11 mask readback", v, 32'h8);

    // acknowledge rules
    wr(1'b1, 32'h0); wr(1'b1, 32'h1); step();
    rd(1'b1, v); check("R5 zero bits leave pending", v, 32'h8);
    wr(1'b1, 32'h8); step(2);
    rd(1'b1, v); check("R5 ack clears", v, 32'h0);
    check("R4 request drops after ack", {31'b0, cpu_irq}, 32'h0);

    // held line reappears after acknowledge
    irq_in[5] = 1'b1; step(3);
    wr(1'b1, 32'h20); step();
    rd(1'b1, v); check("R6 held line pending again", v, 32'h20);
    irq_in[5] = 1'b0; step(2); wr(1'b1, 32'h20); step();
    rd(1'b1, v); check("R3 released line cleared by ack", v, 32'h0);

    // counters: three pulses plus one held assertion
    for (int k = 0; k < 3; k++) begin
      irq_in[7] = 1'b1; step(); irq_in[7] = 1'b0; step();
    end
    irq_in[7] = 1'b1; step(4); irq_in[7] = 1'b0; step();
    rdcnt(7, v); check("R10 line 7 edge count", v, 32'd4);
    rdcnt(5, v); check("R10 line 5 edge count", v, 32'd1);
    rdcnt(9, v); check("R10 idle line count", v, 32'd0);

    // boundary lines
    wr(1'b1, 32'hFFFF_FFFF); wr(1'b0, 32'h0); step();
    irq_in[0] = 1'b1; irq_in[31] = 1'b1; step(); irq_in = '0; step(3);
    rd(1'b1, v); check("R1 lines 0 and 31 pending", v, 32'h8000_0001);
    wr(1'b0, 32'h8000_0000); step(2);
    check("R1 line 31 request", {31'b0, cpu_irq}, 32'h1);
    rd(1'b0, v); check("R11 mask line 31", v, 32'h8000_0000);

    // reset in mid-run
    rst = 1'b1; step(2); rst = 1'b0; step();
    check("R9 request cleared", {31'b0, cpu_irq}, 32'h0);
    rd(1'b0, v); check("R9 mask cleared", v, 32'h0);
    rd(1'b1, v); check("R9 pending cleared", v, 32'h0);
    rdcnt(7, v); check("R9 counter cleared", v, 32'h0);

    step(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule